// File: doc/BRIEF.md
# Interval Timer Host Bus Decoder

This block sits between a byte-wide host port and three timer channels. It takes asynchronous, active-low read and write strobes qualified by an active-low chip select, synchronizes them into the system clock domain and lets a small state machine turn each host access into exactly one single-cycle command for one channel. A two-bit address picks either a channel's data port or the shared control port.

A write to the control port is split into fields. The two top bits name the target channel, or the value 3 marks a read-back command. The next two bits give the byte access format, where 0 means "snapshot the count" (latch) rather than "program". Bits 3:1 carry the counting mode and bit 0 selects BCD counting. Programming carries the normalized mode, the BCD flag and the format to the named channel only. Channel data writes and reads become byte strobes towards the addressed channel. A read mux returns that channel's byte. The control port is write-only, and read-back is only flagged, with its six low bits.

State machine: `S_IDLE` waits for a qualified strobe. Transition *write-start* (chip selected, write low) goes to `S_WRITE`. Transition *read-start* (chip selected, read low, write high) goes to `S_READ`. Both single-cycle states move unconditionally to `S_HOLD`. Transition *release* (chip deselected or both strobes high) returns `S_HOLD` to `S_IDLE`.

Top module: `tmr_host_decode`

## Requirements
- R1: While the synchronized chip select is high, read and write strobes cause no pulse on any output.
- R2: A write to address 0, 1 or 2 pulses `byte_wr` bit n (n = address) once, with `wr_byte` equal to the written data during that pulse.
- R3: A control write (address 3) with channel field bits 7:6 = n < 3 and format bits 5:4 not 00 pulses only `prog_pulse` bit n. During the pulse `prog_fmt` = bits 5:4 and `prog_bcd` = bit 0.
- R4: `prog_mode` equals bits 3:1, except that 110 is given as 010 and 111 as 011.
- R5: A control write with format bits 5:4 = 00 and channel field n < 3 pulses only `latch_pulse` bit n, with no program pulse.
- R6: A control write with channel field 11 pulses `rb_flag` for one cycle with `rb_bits` = data bits 5:0, and no channel pulse.
- R7: A read of address 0, 1 or 2 pulses `byte_rd` bit n once, and while the read is held `rdata` equals byte n of `chan_rdata` (bits 8n+7:8n).
- R8: A read of address 3 pulses no `byte_rd` bit and `rdata` stays 0.
- R9: Each access produces exactly one pulse of one clock cycle, however long the strobe is held, and at most one pulse output is high in any cycle.
- R10: After reset all pulse outputs, `rb_flag` and `rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Port address: 0..2 channel, 3 control |
| wdata | input | 8 | Host write data |
| chan_rdata | input | 24 | Read byte of each channel, channel n at bits 8n+7:8n |
| rdata | output | 8 | Read data to the host |
| byte_wr | output | 3 | Per-channel data byte write pulse |
| wr_byte | output | 8 | Data byte for channel writes |
| byte_rd | output | 3 | Per-channel data byte read pulse |
| prog_pulse | output | 3 | Per-channel program pulse |
| prog_mode | output | 3 | Normalized counting mode |
| prog_bcd | output | 1 | BCD counting flag |
| prog_fmt | output | 2 | Byte access format |
| latch_pulse | output | 3 | Per-channel count snapshot pulse |
| rb_flag | output | 1 | Read-back command seen |
| rb_bits | output | 6 | Low six bits of the read-back command |

## Verification
On every cycle the assertions check that at most one pulse is high, that no pulse lasts beyond one cycle, that a deselected idle decoder issues nothing, that a read-back flag never coincides with a channel command, and that the mode handed to a channel is never 6 or 7. Only the bench scenarios can show that fields land on the correct channel with the correct values, that the read mux returns the right byte, and that a long-held strobe still yields a single command.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NCH  = 3;
    localparam int DW   = 8;
    localparam int AW   = 2;
    localparam logic [AW-1:0] CTRL_ADDR = 2'b11;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WRITE = 2'd1,
        S_READ  = 2'd2,
        S_HOLD  = 2'd3
    } dec_state_t;

    typedef struct packed {
        logic       is_rb;
        logic       is_latch;
        logic [1:0] chan;
        logic [1:0] fmt;
        logic [2:0] mode;
        logic       bcd;
        logic [5:0] rb_bits;
    } ctrl_t;

    function automatic logic [2:0] norm_mode(input logic [2:0] m);
        return (m[1]) ? {1'b0, m[1:0]} : m;
    endfunction
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    pipe[i] <= RST_VAL;
                else if (i == 0)
                    pipe[i] <= d;
                else
                    pipe[i] <= pipe[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode
    import tmr_pkg::*;
(
    input  logic [DW-1:0] cbyte,
    output ctrl_t         fields
);
    always_comb begin
        fields.chan     = cbyte[7:6];
        fields.fmt      = cbyte[5:4];
        fields.mode     = norm_mode(cbyte[3:1]);
        fields.bcd      = cbyte[0];
        fields.rb_bits  = cbyte[5:0];
        fields.is_rb    = (cbyte[7:6] == 2'b11);
        fields.is_latch = (cbyte[7:6] != 2'b11) && (cbyte[5:4] == 2'b00);
    end
endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux
    import tmr_pkg::*;
(
    input  logic [AW-1:0]     sel,
    input  logic              en,
    input  logic [NCH*DW-1:0] bytes_in,
    output logic [DW-1:0]     byte_out
);
    logic [DW-1:0] slot [NCH];

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_slot
            assign slot[i] = bytes_in[i*DW +: DW];
        end
    endgenerate

    always_comb begin
        byte_out = '0;
        for (int i = 0; i < NCH; i++)
            if (en && sel == AW'(i))
                byte_out = slot[i];
    end
endmodule

// File: rtl/tmr_host_decode.sv
module tmr_host_decode
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    input  logic [23:0]       chan_rdata,
    output logic [7:0]        rdata,
    output logic [2:0]        byte_wr,
    output logic [7:0]        wr_byte,
    output logic [2:0]        byte_rd,
    output logic [2:0]        prog_pulse,
    output logic [2:0]        prog_mode,
    output logic              prog_bcd,
    output logic [1:0]        prog_fmt,
    output logic [2:0]        latch_pulse,
    output logic              rb_flag,
    output logic [5:0]        rb_bits
);
    localparam int SW = 3 + AW + DW;

    logic [SW-1:0] raw_bus, sync_bus;
    logic          cs_s, rd_s, wr_s;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] data_s;

    assign raw_bus = {cs_n, rd_n, wr_n, addr, wdata};

    tmr_sync #(
        .W(SW), .STAGES(SYNC_STAGES),
        .RST_VAL({3'b111, {(AW+DW){1'b0}}})
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
    );

    assign {cs_s, rd_s, wr_s, addr_s, data_s} = sync_bus;

    logic wr_req, rd_req;
    assign wr_req = !cs_s && !wr_s;
    assign rd_req = !cs_s && !rd_s;

    dec_state_t    state, nxt;
    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cap_data;
    ctrl_t         cf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && (wr_req || rd_req)) begin
                cap_addr <= addr_s;
                cap_data <= data_s;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (wr_req)      nxt = S_WRITE;
                else if (rd_req) nxt = S_READ;
            end
            S_WRITE: nxt = S_HOLD;
            S_READ:  nxt = S_HOLD;
            S_HOLD:  if (cs_s || (wr_s && rd_s)) nxt = S_IDLE;
        endcase
    end

    tmr_ctrl_decode u_cdec (.cbyte(cap_data), .fields(cf));

    always_comb begin
        byte_wr     = '0;
        byte_rd     = '0;
        prog_pulse  = '0;
        latch_pulse = '0;
        rb_flag     = 1'b0;
        wr_byte     = cap_data;
        prog_mode   = cf.mode;
        prog_bcd    = cf.bcd;
        prog_fmt    = cf.fmt;
        rb_bits     = cf.rb_bits;
        unique case (state)
            S_WRITE: begin
                if (cap_addr == CTRL_ADDR) begin
                    if (cf.is_rb)         rb_flag = 1'b1;
                    else if (cf.is_latch) latch_pulse[cf.chan] = 1'b1;
                    else                  prog_pulse[cf.chan]  = 1'b1;
                end else begin
                    byte_wr[cap_addr] = 1'b1;
                end
            end
            S_READ: begin
                if (cap_addr != CTRL_ADDR) byte_rd[cap_addr] = 1'b1;
            end
            default: ;
        endcase
    end

    tmr_read_mux u_rmux (
        .sel(addr_s), .en(rd_req), .bytes_in(chan_rdata), .byte_out(rdata)
    );

    logic [12:0] all_pulses;
    assign all_pulses = {byte_wr, byte_rd, prog_pulse, latch_pulse, rb_flag};

    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(all_pulses));

    a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (all_pulses != '0) |=> (all_pulses == '0));

    a_r1_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && cs_s) |=> (all_pulses == '0));

    a_r6_rb_alone: assert property (@(posedge clk) disable iff (!rst_n)
        rb_flag |-> (prog_pulse == '0 && latch_pulse == '0 && byte_wr == '0));

    a_r4_mode_range: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_pulse != '0) |-> (prog_mode <= 3'd5));

    a_r8_ctrl_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && addr_s == CTRL_ADDR) |-> (rdata == '0));
endmodule

// File: tb/sim_tmr_host_decode.sv
module sim_tmr_host_decode;
    logic        clk = 0, rst_n = 0;
    logic        cs_n = 1, rd_n = 1, wr_n = 1;
    logic [1:0]  addr = 0;
    logic [7:0]  wdata = 0;
    logic [23:0] chan_rdata = {8'hC2, 8'hB1, 8'hA0};
    logic [7:0]  rdata, wr_byte;
    logic [2:0]  byte_wr, byte_rd, prog_pulse, latch_pulse, prog_mode;
    logic        prog_bcd, rb_flag;
    logic [1:0]  prog_fmt;
    logic [5:0]  rb_bits;

    int errors = 0, checks = 0;

    always #5 clk = ~clk;

    tmr_host_decode u0 (.*);

    // pulse capture, sampled away from the rising edge
    logic [2:0] c_wr, c_rd, c_prog, c_lat;
    logic       c_rb;
    logic [7:0] c_byte;
    logic [2:0] c_mode;
    logic       c_bcd;
    logic [1:0] c_fmt;
    logic [5:0] c_rbb;
    int         c_cnt;

    task automatic clr_cap();
        c_wr = 0; c_rd = 0; c_prog = 0; c_lat = 0; c_rb = 0;
        c_byte = 0; c_mode = 0; c_bcd = 0; c_fmt = 0; c_rbb = 0; c_cnt = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if ({byte_wr, byte_rd, prog_pulse, latch_pulse, rb_flag} != 0) c_cnt++;
            c_wr |= byte_wr; c_rd |= byte_rd; c_prog |= prog_pulse;
            c_lat |= latch_pulse; c_rb |= rb_flag;
            if (byte_wr != 0)    c_byte = wr_byte;
            if (prog_pulse != 0) begin c_mode = prog_mode; c_bcd = prog_bcd; c_fmt = prog_fmt; end
            if (rb_flag)         c_rbb = rb_bits;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [7:0] rd_seen;

    task automatic access(input bit is_rd, input logic [1:0] a, input logic [7:0] d,
                          input bit sel, input int hold);
        clr_cap();
        @(negedge clk);
        addr = a; wdata = d; cs_n = !sel;
        @(negedge clk);
        if (is_rd) rd_n = 0; else wr_n = 0;
        repeat (hold) @(negedge clk);
        rd_seen = rdata;
        rd_n = 1; wr_n = 1;
        @(negedge clk);
        cs_n = 1;
        repeat (6) @(negedge clk);
    endtask

    typedef struct packed {
        logic       rd;
        logic [1:0] a;
        logic [7:0] d;
        logic [2:0] ewr, eprog, elat, erd;
        logic       erb;
        logic [2:0] emode;
        logic       ebcd;
        logic [1:0] efmt;
        logic [7:0] ebyte;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd0, 8'h5A, 3'b001, 3'b000, 3'b000, 3'b000, 1'b0, 3'd0, 1'b0, 2'd0, 8'h5A},
        '{1'b0, 2'd2, 8'h33, 3'b100, 3'b000, 3'b000, 3'b000, 1'b0, 3'd0, 1'b0, 2'd0, 8'h33},
        '{1'b0, 2'd3, 8'h77, 3'b000, 3'b010, 3'b000, 3'b000, 1'b0, 3'd3, 1'b1, 2'd3, 8'h00},
        '{1'b0, 2'd3, 8'h9C, 3'b000, 3'b100, 3'b000, 3'b000, 1'b0, 3'd2, 1'b0, 2'd1, 8'h00},
        '{1'b0, 2'd3, 8'h2E, 3'b000, 3'b001, 3'b000, 3'b000, 1'b0, 3'd3, 1'b0, 2'd2, 8'h00},
        '{1'b0, 2'd3, 8'h4B, 3'b000, 3'b000, 3'b010, 3'b000, 1'b0, 3'd0, 1'b0, 2'd0, 8'h00},
        '{1'b0, 2'd3, 8'hEA, 3'b000, 3'b000, 3'b000, 3'b000, 1'b1, 3'd0, 1'b0, 2'd0, 8'h2A},
        '{1'b1, 2'd1, 8'h00, 3'b000, 3'b000, 3'b000, 3'b010, 1'b0, 3'd0, 1'b0, 2'd0, 8'hB1},
        '{1'b1, 2'd3, 8'h00, 3'b000, 3'b000, 3'b000, 3'b000, 1'b0, 3'd0, 1'b0, 2'd0, 8'h00},
        '{1'b0, 2'd3, 8'h38, 3'b000, 3'b001, 3'b000, 3'b000, 1'b0, 3'd4, 1'b0, 2'd3, 8'h00}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clr_cap();
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 pulses in reset", {byte_wr, byte_rd, prog_pulse, latch_pulse, rb_flag}, 0);
        chk("R10 rdata in reset", rdata, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk("R10 pulses after reset", c_cnt, 0);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].rd, VEC[i].a, VEC[i].d, 1'b1, 5);
            chk("R2 byte_wr", c_wr, VEC[i].ewr);
            chk("R3 prog_pulse", c_prog, VEC[i].eprog);
            chk("R5 latch_pulse", c_lat, VEC[i].elat);
            chk("R6 rb_flag", c_rb, VEC[i].erb);
            chk("R7 byte_rd", c_rd, VEC[i].erd);
            chk("R9 pulse count", c_cnt,
                (VEC[i].ewr | VEC[i].eprog | VEC[i].elat | VEC[i].erd | {2'b0, VEC[i].erb}) != 0 ? 1 : 0);
            if (VEC[i].ewr != 0) chk("R2 wr_byte", c_byte, VEC[i].ebyte);
            if (VEC[i].eprog != 0) begin
                chk("R4 prog_mode", c_mode, VEC[i].emode);
                chk("R3 prog_bcd", c_bcd, VEC[i].ebcd);
                chk("R3 prog_fmt", c_fmt, VEC[i].efmt);
            end
            if (VEC[i].erb) chk("R6 rb_bits", c_rbb, VEC[i].ebyte[5:0]);
            if (VEC[i].rd && VEC[i].a != 3) chk("R7 rdata", rd_seen, VEC[i].ebyte);
            if (VEC[i].rd && VEC[i].a == 3) chk("R8 rdata", rd_seen, 8'h00);
        end

        // R1: deselected write and read do nothing
        access(1'b0, 2'd1, 8'h11, 1'b0, 5);
        chk("R1 deselected write", c_cnt, 0);
        access(1'b1, 2'd0, 8'h00, 1'b0, 5);
        chk("R1 deselected read", c_cnt, 0);
        chk("R1 deselected rdata", rd_seen, 0);

        // R9: long-held strobe yields one pulse
        access(1'b0, 2'd1, 8'hC3, 1'b1, 40);
        chk("R9 long write count", c_cnt, 1);
        chk("R2 long write target", c_wr, 3'b010);
        access(1'b1, 2'd2, 8'h00, 1'b1, 40);
        chk("R9 long read count", c_cnt, 1);
        chk("R7 long read data", rd_seen, 8'hC2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule